// File: doc/BRIEF.md
# Nonvolatile Write Control and Status

This block is the sequencing core behind a serial EEPROM front end. The serial front end decodes each instruction and presents it as a start event with an opcode and a byte address. Data bytes arrive one at a time. An end event marks chip deselect, together with a flag that says whether the clock count was a whole number of bytes. The block keeps a two-bit status word holding a write-enable latch and a busy flag. It decides whether each modifying instruction is accepted, and then runs a timed cycle that drives erase and program strobes toward the cell array.

The array has two regions with different cycle types. The pages below a configurable boundary form the event sector. A page program there is one short program phase, and the array is assumed to have erased those bytes earlier. The rest of the pages form the data sector. A page write there runs a full erase phase and then a program phase. An active-low write-protect pin makes the event sector read-only. An active-low reset pin holds the block quiet without cutting short a cycle that has already started. All phase lengths are parameters in clock ticks.

Top module: `nvwc_ctrl`

## Requirements
- R1: A modifying instruction (page write 4, page program 5, page erase 6, sector erase 7 on `cmd_op`) starts no cycle unless the write-enable latch was set when its end event arrived.
- R2: Write enable (opcode 1) sets the latch and write disable (opcode 2) clears it. Each takes effect at its end event. The latch also clears on the clock edge that ends an accepted cycle.
- R3: While `hold_n` is low, the latch is cleared and every new instruction is ignored. A cycle already running continues through all its phases, keeps the busy flag high until its normal end, and the busy flag then falls.
- R4: While `wp_n` is low, any modifying instruction whose page index is below `evt_pages` is refused, and the latch keeps its value. Pages at or above the boundary are not affected.
- R5: An accepted page write runs an erase phase of `T_ERASE` clocks and then a program phase of `T_PROG` clocks. The busy flag is high from the clock after the end event for `T_ERASE+T_PROG` clocks.
- R6: An accepted page program is one program phase with no erase. It lasts `T_FAST` clocks in the event sector and `T_PROG` clocks in the data sector.
- R7: Page erase is one erase phase of `T_ERASE` clocks with `arr_whole` low. Sector erase is the same but with `arr_whole` high. In both, `arr_evt` names the sector that holds the addressed page.
- R8: During a page write or page program, each data byte raises `buf_we` with `buf_col`. The column starts at the low address byte, rises by one per byte, and wraps from 255 to 0.
- R9: While the busy flag is high, all instructions (including write enable and write disable) are ignored, but the status word stays readable.
- R10: An instruction whose end event has `cmd_aligned` low is ignored entirely.
- R11: `status` bit 0 is the busy flag, bit 1 is the write-enable latch, and bits 7:2 read zero. Both flags are zero after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hold_n | input | 1 | Active-low functional reset pin |
| wp_n | input | 1 | Active-low write protect for the event sector |
| evt_pages | input | PG_IDX_W+1 | Number of pages, from page 0, that form the event sector |
| cmd_start | input | 1 | Opcode and address are valid |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Byte address |
| dat_valid | input | 1 | One data byte received |
| cmd_end | input | 1 | Deselect; the instruction is complete |
| cmd_aligned | input | 1 | The clock count was a multiple of eight |
| status | output | 8 | Status word |
| buf_we | output | 1 | Page latch write strobe |
| buf_col | output | PAGE_W | Page latch column |
| arr_erase | output | 1 | Erase phase active |
| arr_prog | output | 1 | Program phase active |
| arr_whole | output | 1 | Erase covers the whole sector |
| arr_evt | output | 1 | Target lies in the event sector |
| arr_page | output | PG_IDX_W | Target page index |

## Verification
The bench counts erase and program clocks for each kind of cycle in both sectors. A sequencer that skipped the erase phase of a page write, or that used the fast length in the data sector, gives the wrong counts. It sends instructions without the latch set, with protection on at the sector boundary, and with an unaligned deselect, so a design that accepted any of them would start a cycle. During a cycle it pulses the reset pin and sends a write disable and an erase. A design that aborted the cycle, honoured the disable, or queued the erase would show a short busy window, a lost latch, or a second cycle. The column wrap is watched byte by byte across the 255-to-0 boundary.

// File: rtl/nvwc_pkg.sv
package nvwc_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_WREN = 3'd1,
    OP_WRDI = 3'd2,
    OP_RDSR = 3'd3,
    OP_PW   = 3'd4,
    OP_PP   = 3'd5,
    OP_PE   = 3'd6,
    OP_SE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } ph_e;

  typedef enum logic [1:0] {
    JOB_WRITE = 2'd0,
    JOB_FAST  = 2'd1,
    JOB_PROG  = 2'd2,
    JOB_ERASE = 2'd3
  } job_e;
endpackage

// File: rtl/nvwc_cmd_gate.sv
module nvwc_cmd_gate
  import nvwc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 8,
  parameter int PG_IDX_W = ADDR_W - PAGE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_n,
  input  logic                wp_n,
  input  logic                busy,
  input  logic                wel,
  input  logic [PG_IDX_W:0]   evt_pages,
  input  logic                cmd_start,
  input  logic [2:0]          cmd_op,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic                dat_valid,
  input  logic                cmd_end,
  input  logic                cmd_aligned,
  output logic                buf_we,
  output logic [PAGE_W-1:0]   buf_col,
  output logic                go,
  output job_e                go_job,
  output logic [PG_IDX_W-1:0] go_page,
  output logic                go_whole,
  output logic                go_evt,
  output logic                wel_set,
  output logic                wel_clr
);
  logic                act_q, act_d;
  op_e                 op_q, op_d;
  logic [PG_IDX_W-1:0] page_q, page_d;
  logic [PAGE_W-1:0]   col_q, col_d;
  logic                fire, modify, is_evt, blocked;

  always_comb begin
    buf_we  = act_q & dat_valid & hold_n & ((op_q == OP_PW) | (op_q == OP_PP));
    buf_col = col_q;
    act_d   = act_q;
    op_d    = op_q;
    page_d  = page_q;
    col_d   = col_q;
    if (cmd_start && hold_n && !busy) begin
      act_d  = 1'b1;
      op_d   = op_e'(cmd_op);
      page_d = cmd_addr[ADDR_W-1:PAGE_W];
      col_d  = cmd_addr[PAGE_W-1:0];
    end else begin
      if (cmd_end || !hold_n) act_d = 1'b0;
      if (buf_we) col_d = col_q + 1'b1;
    end
  end

  always_comb begin
    fire     = act_q & cmd_end & cmd_aligned & hold_n & ~busy;
    modify   = (op_q == OP_PW) | (op_q == OP_PP) | (op_q == OP_PE) | (op_q == OP_SE);
    is_evt   = ({1'b0, page_q} < evt_pages);
    blocked  = is_evt & ~wp_n;
    go       = fire & modify & wel & ~blocked;
    wel_set  = fire & (op_q == OP_WREN);
    wel_clr  = fire & (op_q == OP_WRDI);
    go_page  = page_q;
    go_whole = (op_q == OP_SE);
    go_evt   = is_evt;
    case (op_q)
      OP_PW:   go_job = JOB_WRITE;
      OP_PP:   go_job = is_evt ? JOB_FAST : JOB_PROG;
      default: go_job = JOB_ERASE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      op_q   <= OP_NOP;
      page_q <= '0;
      col_q  <= '0;
    end else begin
      act_q  <= act_d;
      op_q   <= op_d;
      page_q <= page_d;
      col_q  <= col_d;
    end
  end

  AST_NO_GO_WHEN_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wp_n) |-> !go_evt) else $error("protected sector start"); // R4
  AST_COL_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !cmd_start) |=> (buf_col == $past(buf_col) + 1'b1)) else $error("column step"); // R8
endmodule

// File: rtl/nvwc_cycle_timer.sv
module nvwc_cycle_timer
  import nvwc_pkg::*;
#(
  parameter int PG_IDX_W = 4,
  parameter int T_ERASE  = 40,
  parameter int T_PROG   = 40,
  parameter int T_FAST   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  job_e                go_job,
  input  logic [PG_IDX_W-1:0] go_page,
  input  logic                go_whole,
  input  logic                go_evt,
  output logic                busy,
  output logic                done,
  output logic                arr_erase,
  output logic                arr_prog,
  output logic                arr_whole,
  output logic                arr_evt,
  output logic [PG_IDX_W-1:0] arr_page
);
  localparam int TMAX  = (T_ERASE > T_PROG) ? ((T_ERASE > T_FAST) ? T_ERASE : T_FAST)
                                            : ((T_PROG > T_FAST) ? T_PROG : T_FAST);
  localparam int CNT_W = $clog2(TMAX + 1);

  ph_e                 ph_q, ph_d;
  job_e                job_q, job_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [PG_IDX_W-1:0] page_q, page_d;
  logic                whole_q, whole_d, evt_q, evt_d;

  always_comb begin
    ph_d    = ph_q;
    job_d   = job_q;
    cnt_d   = cnt_q;
    page_d  = page_q;
    whole_d = whole_q;
    evt_d   = evt_q;
    done    = 1'b0;
    case (ph_q)
      PH_IDLE: if (go) begin
        job_d   = go_job;
        page_d  = go_page;
        whole_d = go_whole;
        evt_d   = go_evt;
        case (go_job)
          JOB_FAST: begin ph_d = PH_PROG;  cnt_d = CNT_W'(T_FAST - 1);  end
          JOB_PROG: begin ph_d = PH_PROG;  cnt_d = CNT_W'(T_PROG - 1);  end
          default:  begin ph_d = PH_ERASE; cnt_d = CNT_W'(T_ERASE - 1); end
        endcase
      end
      PH_ERASE: begin
        if (cnt_q == '0) begin
          if (job_q == JOB_WRITE) begin
            ph_d  = PH_PROG;
            cnt_d = CNT_W'(T_PROG - 1);
          end else begin
            ph_d = PH_IDLE;
            done = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PROG: begin
        if (cnt_q == '0) begin
          ph_d = PH_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      job_q   <= JOB_ERASE;
      cnt_q   <= '0;
      page_q  <= '0;
      whole_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      job_q   <= job_d;
      cnt_q   <= cnt_d;
      page_q  <= page_d;
      whole_q <= whole_d;
      evt_q   <= evt_d;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign arr_erase = (ph_q == PH_ERASE);
  assign arr_prog  = (ph_q == PH_PROG);
  assign arr_whole = whole_q;
  assign arr_evt   = evt_q;
  assign arr_page  = page_q;

  AST_WRITE_ERASES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arr_prog) && job_q == JOB_WRITE) |-> $past(arr_erase)) else $error("write order"); // R5
  AST_FAST_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && job_q == JOB_FAST) |-> !arr_erase) else $error("fast erased"); // R6
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_page)) else $error("target moved"); // R7
endmodule

// File: rtl/nvwc_ctrl.sv
module nvwc_ctrl
  import nvwc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 8,
  parameter int T_ERASE  = 40,
  parameter int T_PROG   = 40,
  parameter int T_FAST   = 16,
  parameter int PG_IDX_W = ADDR_W - PAGE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_n,
  input  logic                wp_n,
  input  logic [PG_IDX_W:0]   evt_pages,
  input  logic                cmd_start,
  input  logic [2:0]          cmd_op,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic                dat_valid,
  input  logic                cmd_end,
  input  logic                cmd_aligned,
  output logic [7:0]          status,
  output logic                buf_we,
  output logic [PAGE_W-1:0]   buf_col,
  output logic                arr_erase,
  output logic                arr_prog,
  output logic                arr_whole,
  output logic                arr_evt,
  output logic [PG_IDX_W-1:0] arr_page
);
  logic                busy, done, go, wel_set, wel_clr, go_whole, go_evt;
  job_e                go_job;
  logic [PG_IDX_W-1:0] go_page;
  logic                wel_q, wel_d;

  nvwc_cmd_gate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PG_IDX_W(PG_IDX_W)) gate_i (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .wp_n(wp_n), .busy(busy), .wel(wel_q),
    .evt_pages(evt_pages), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .dat_valid(dat_valid), .cmd_end(cmd_end), .cmd_aligned(cmd_aligned),
    .buf_we(buf_we), .buf_col(buf_col), .go(go), .go_job(go_job), .go_page(go_page),
    .go_whole(go_whole), .go_evt(go_evt), .wel_set(wel_set), .wel_clr(wel_clr)
  );

  nvwc_cycle_timer #(.PG_IDX_W(PG_IDX_W), .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_FAST(T_FAST)) timer_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_job(go_job), .go_page(go_page),
    .go_whole(go_whole), .go_evt(go_evt), .busy(busy), .done(done),
    .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_whole(arr_whole),
    .arr_evt(arr_evt), .arr_page(arr_page)
  );

  always_comb begin
    wel_d = wel_q;
    if (!hold_n || done || wel_clr) wel_d = 1'b0;
    else if (wel_set)               wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  assign status = {6'b0, wel_q, busy};

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel_q)) else $error("start without latch"); // R1
  AST_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel_q) else $error("latch survived end"); // R2
  AST_HOLD_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> !wel_q) else $error("latch under hold"); // R3
  AST_PROTECT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !(arr_evt && !$past(wp_n))) else $error("protected start"); // R4
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:2] == 6'b0) else $error("status pad"); // R11
endmodule

// File: tb/nvwc_ctrl_tb_top.sv
module nvwc_ctrl_tb_top;
  localparam int TE = 40;
  localparam int TP = 40;
  localparam int TF = 16;

  logic        clk = 1'b0;
  logic        rst_n, hold_n, wp_n;
  logic [4:0]  evt_pages;
  logic        cmd_start, dat_valid, cmd_end, cmd_aligned;
  logic [2:0]  cmd_op;
  logic [11:0] cmd_addr;
  logic [7:0]  status;
  logic        buf_we, arr_erase, arr_prog, arr_whole, arr_evt;
  logic [7:0]  buf_col;
  logic [3:0]  arr_page;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  nvwc_ctrl #(.T_ERASE(TE), .T_PROG(TP), .T_FAST(TF)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .wp_n(wp_n), .evt_pages(evt_pages),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .dat_valid(dat_valid),
    .cmd_end(cmd_end), .cmd_aligned(cmd_aligned), .status(status), .buf_we(buf_we),
    .buf_col(buf_col), .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_whole(arr_whole),
    .arr_evt(arr_evt), .arr_page(arr_page)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        wren;
    logic [2:0]  op;
    logic [11:0] addr;
    logic        wp;
    logic        al;
    logic [7:0]  ne;
    logic [7:0]  np;
    logic        wh;
    logic        ev;
    logic        wl;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'd5,  1'b1, 3'd4, 12'h500, 1'b1, 1'b1, 8'd40, 8'd40, 1'b0, 1'b0, 1'b0}, // R5 data write
    '{4'd1,  1'b0, 3'd4, 12'h500, 1'b1, 1'b1, 8'd0,  8'd0,  1'b0, 1'b0, 1'b0}, // R1 no latch
    '{4'd6,  1'b1, 3'd5, 12'h100, 1'b1, 1'b1, 8'd0,  8'd16, 1'b0, 1'b1, 1'b0}, // R6 fast
    '{4'd6,  1'b1, 3'd5, 12'h600, 1'b1, 1'b1, 8'd0,  8'd40, 1'b0, 1'b0, 1'b0}, // R6 slow
    '{4'd4,  1'b1, 3'd6, 12'h200, 1'b0, 1'b1, 8'd0,  8'd0,  1'b0, 1'b0, 1'b1}, // R4 refused
    '{4'd4,  1'b1, 3'd6, 12'h900, 1'b0, 1'b1, 8'd40, 8'd0,  1'b0, 1'b0, 1'b0}, // R4 data ok
    '{4'd7,  1'b1, 3'd7, 12'h300, 1'b1, 1'b1, 8'd40, 8'd0,  1'b1, 1'b1, 1'b0}, // R7 evt sector
    '{4'd7,  1'b1, 3'd7, 12'hA00, 1'b1, 1'b1, 8'd40, 8'd0,  1'b1, 1'b0, 1'b0}, // R7 data sector
    '{4'd10, 1'b1, 3'd5, 12'h100, 1'b1, 1'b0, 8'd0,  8'd0,  1'b0, 1'b0, 1'b1}, // R10 unaligned
    '{4'd4,  1'b1, 3'd4, 12'h000, 1'b0, 1'b1, 8'd0,  8'd0,  1'b0, 1'b0, 1'b1}  // R4 page 0
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [11:0] addr, input int nb,
                      input logic al, input bit chk_col);
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      dat_valid = 1'b1;
      #1;
      if (chk_col) begin
        check(buf_we == 1'b1, "R8 we", int'(buf_we), 1);
        check(buf_col == 8'(addr[7:0] + i), "R8 col", int'(buf_col), int'(8'(addr[7:0] + i)));
      end
      @(negedge clk);
    end
    dat_valid = 1'b0;
    cmd_end = 1'b1; cmd_aligned = al;
    @(negedge clk);
    cmd_end = 1'b0; cmd_aligned = 1'b1;
  endtask

  int cyc, ne, np;
  logic wh, ev;

  task automatic measure();
    cyc = 0; ne = 0; np = 0; wh = 1'b0; ev = 1'b0;
    while (status[0] && cyc < 1000) begin
      if (cyc == 0) begin wh = arr_whole; ev = arr_evt; end
      if (arr_erase) ne++;
      if (arr_prog) np++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold_n = 1'b1; wp_n = 1'b1; evt_pages = 5'd4;
    cmd_start = 1'b0; cmd_op = 3'd0; cmd_addr = '0; dat_valid = 1'b0;
    cmd_end = 1'b0; cmd_aligned = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R11 reset status", int'(status), 0);
    check(buf_we == 1'b0, "R11 reset buf_we", int'(buf_we), 0);

    send(3'd1, 12'h0, 0, 1'b1, 1'b0);
    check(status == 8'h02, "R2 wren", int'(status), 2);
    send(3'd2, 12'h0, 0, 1'b1, 1'b0);
    check(status == 8'h00, "R2 wrdi", int'(status), 0);

    for (int v = 0; v < 10; v++) begin
      if (VEC[v].wren) send(3'd1, 12'h0, 0, 1'b1, 1'b0);
      wp_n = VEC[v].wp;
      send(VEC[v].op, VEC[v].addr, (VEC[v].op == 3'd4 || VEC[v].op == 3'd5) ? 2 : 0,
           VEC[v].al, 1'b0);
      measure();
      check(ne == int'(VEC[v].ne), $sformatf("R%0d vec%0d erase", VEC[v].rq, v), ne, int'(VEC[v].ne));
      check(np == int'(VEC[v].np), $sformatf("R%0d vec%0d prog", VEC[v].rq, v), np, int'(VEC[v].np));
      if (VEC[v].ne + VEC[v].np != 0) begin
        check(wh == VEC[v].wh, $sformatf("R%0d vec%0d whole", VEC[v].rq, v), int'(wh), int'(VEC[v].wh));
        check(ev == VEC[v].ev, $sformatf("R%0d vec%0d evt", VEC[v].rq, v), int'(ev), int'(VEC[v].ev));
      end
      check(status[1] == VEC[v].wl, $sformatf("R%0d vec%0d wel after", VEC[v].rq, v),
            int'(status[1]), int'(VEC[v].wl));
      wp_n = 1'b1;
    end

    // R8: column wrap from 0xFE across 255 to 0
    send(3'd2, 12'h0, 0, 1'b1, 1'b0);
    send(3'd5, 12'h0FE, 4, 1'b1, 1'b1);

    // R9: commands during a busy cycle are ignored
    send(3'd1, 12'h0, 0, 1'b1, 1'b0);
    send(3'd4, 12'h500, 0, 1'b1, 1'b0);
    cyc = 0;
    repeat (5) begin @(negedge clk); cyc++; end
    send(3'd2, 12'h0, 0, 1'b1, 1'b0); cyc += 3;
    check(status == 8'h03, "R9 wrdi while busy", int'(status), 3);
    send(3'd6, 12'h900, 0, 1'b1, 1'b0); cyc += 3;
    while (status[0] && cyc < 1000) begin @(negedge clk); cyc++; end
    check(cyc == TE + TP, "R9 busy length", cyc, TE + TP);
    repeat (2) @(negedge clk);
    check(status == 8'h00, "R9 no queued erase", int'(status), 0);

    // R3: reset pin mid-cycle
    send(3'd1, 12'h0, 0, 1'b1, 1'b0);
    send(3'd4, 12'h500, 0, 1'b1, 1'b0);
    cyc = 0;
    while (status[0] && cyc < 1000) begin
      if (cyc == 10) hold_n = 1'b0;
      @(negedge clk);
      cyc++;
      if (cyc == 11) check(status == 8'h01, "R3 wel cleared, cycle runs", int'(status), 1);
    end
    check(cyc == TE + TP, "R3 cycle completes", cyc, TE + TP);
    send(3'd1, 12'h0, 0, 1'b1, 1'b0);
    check(status == 8'h00, "R3 wren ignored in hold", int'(status), 0);
    hold_n = 1'b1;
    send(3'd1, 12'h0, 0, 1'b1, 1'b0);
    check(status == 8'h02, "R3 wren after release", int'(status), 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule